// File: doc/BRIEF.md
# SCL divider parameter calculator

This block turns a requested SCL divisor into the settings an SCL generator uses. The divisor is the number of parent clock cycles in one SCL period. The settings are a power-of-two prescale exponent, a high-phase count and a low-phase count.

The block picks the smallest prescale exponent for which the prescaled count fits the two phase fields. The count is rounded up and split into a high phase and a low phase, with the high phase never the shorter of the two. Each phase is stored minus one, since a stored value of n means n+1 prescaled cycles. When no exponent the 4-bit field can hold is large enough, every field saturates and a clamp flag is raised.

A start pulse launches an iterative search that tests one exponent per cycle. A single-cycle done pulse marks the result, and the result is held until the next calculation completes. The parameter `PHASE_W` sets the width of each phase field to 3 or 4 bits.

Top module: `scl_div_calc`

## Requirements
- R1: After reset, `done_o`, `clamp_o`, `exp_o`, `high_o`, `low_o` and `reg_o` are all zero.
- R2: With limit L = 2^(PHASE_W+1) (16 for 3-bit fields, 32 for 4-bit fields), `exp_o` is 0 for a divisor d ≤ L. Otherwise it is the smallest e with ceil(d / 2^e) ≤ L, which equals floor(log2((d-1)/L)) + 1.
- R3: The scaled count is s = ceil(d / 2^e). The low phase is floor(s/2) and the high phase is s minus the low phase. Each phase is encoded minus one, except that a zero stays zero. A divisor of 0 or 1 gives zero in every field.
- R4: When `clamp_o` is 0, `high_o` ≥ `low_o`.
- R5: If the exponent found under R2 would exceed 15, then `exp_o` = 15, `high_o` and `low_o` are all ones, and `clamp_o` = 1. Otherwise `clamp_o` = 0.
- R6: `done_o` is high for exactly one cycle per accepted start. It rises at most 19 cycles after the cycle in which `start_i` is sampled.
- R7: A `start_i` pulse arriving while a calculation is in progress is ignored. The result returned is that of the first divisor.
- R8: All result outputs hold their value between done pulses. A change on `divisor_i` without a start has no effect on them.
- R9: `reg_o` holds the exponent in bits [3:0], the low field starting at bit 16 and the high field starting at bit 24. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a calculation on `divisor_i`; only accepted when idle |
| divisor_i | input | 32 | Requested parent clock cycles per SCL period |
| done_o | output | 1 | Single-cycle pulse when a new result is available |
| clamp_o | output | 1 | Divisor beyond the reachable range; all fields saturated |
| exp_o | output | 4 | Prescale exponent |
| high_o | output | PHASE_W | High-phase count, minus-one encoded |
| low_o | output | PHASE_W | Low-phase count, minus-one encoded |
| reg_o | output | 32 | Packed result word |

## Verification
The bench builds two instances from the same stimulus, one with `PHASE_W` = 4 and one with `PHASE_W` = 3. Both sets of phase limits, 32 and 16, are therefore checked against an arithmetic model. An exhaustive sweep of small divisors covers every rounding and split case, including the zero and one divisors and the step from exponent 0 to 1. Added points at each power of two, and next to each one, reach every exponent up to 15. The largest unclamped divisor of each width and the divisor just above it reach the saturation boundary, and the largest 32-bit value is also applied.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned EXP_W = 4;
  localparam int unsigned DIV_W = 32;
  localparam int unsigned LO_POS = 16;
  localparam int unsigned HI_POS = 24;

  typedef enum logic {
    ST_IDLE,
    ST_SEARCH
  } search_st_e;
endpackage

// File: rtl/scl_div_prescale.sv
module scl_div_prescale
  import scl_div_pkg::*;
#(
  parameter int unsigned MAX_CNT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DIV_W-1:0] div_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             clamp_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  search_st_e       st_q;
  logic [DIV_W-1:0] shv_q;

  // shv_q holds (d-1) >> e; the search stops at the first e where it drops below MAX_CNT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      shv_q   <= '0;
      div_o   <= '0;
      exp_o   <= '0;
      clamp_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q    <= ST_SEARCH;
            div_o   <= divisor_i;
            shv_q   <= (divisor_i == '0) ? '0 : divisor_i - 1'b1;
            exp_o   <= '0;
            clamp_o <= 1'b0;
          end
        end
        default: begin
          if (shv_q < DIV_W'(MAX_CNT)) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else if (exp_o == EXP_MAX) begin
            st_q    <= ST_IDLE;
            clamp_o <= 1'b1;
            done_o  <= 1'b1;
          end else begin
            shv_q <= shv_q >> 1;
            exp_o <= exp_o + 1'b1;
          end
        end
      endcase
    end
  end

  // R7
  busy_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH) |=> $stable(div_o));

  // R2
  shift_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH && !done_o) |=> shv_q <= $past(shv_q));
endmodule

// File: rtl/scl_div_split.sv
module scl_div_split
  import scl_div_pkg::*;
#(
  parameter int unsigned PHASE_W = 4
) (
  input  logic [DIV_W-1:0]   div_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic               clamp_i,
  output logic [PHASE_W-1:0] high_o,
  output logic [PHASE_W-1:0] low_o
);
  localparam int unsigned CNT_W = PHASE_W + 2;

  logic [DIV_W:0]   round_sum;
  logic [DIV_W:0]   scaled_full;
  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] lo_cnt;
  logic [CNT_W-1:0] hi_cnt;

  always_comb begin
    round_sum   = {1'b0, div_i} + ((DIV_W + 1)'(1) << exp_i) - 1'b1;
    scaled_full = round_sum >> exp_i;
    scaled      = scaled_full[CNT_W-1:0];
    lo_cnt      = scaled >> 1;
    hi_cnt      = scaled - lo_cnt;
    if (hi_cnt != '0) hi_cnt = hi_cnt - 1'b1;
    if (lo_cnt != '0) lo_cnt = lo_cnt - 1'b1;
    if (clamp_i) begin
      high_o = '1;
      low_o  = '1;
    end else begin
      high_o = hi_cnt[PHASE_W-1:0];
      low_o  = lo_cnt[PHASE_W-1:0];
    end
  end
endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc
  import scl_div_pkg::*;
#(
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [31:0]        divisor_i,
  output logic               done_o,
  output logic               clamp_o,
  output logic [3:0]         exp_o,
  output logic [PHASE_W-1:0] high_o,
  output logic [PHASE_W-1:0] low_o,
  output logic [31:0]        reg_o
);
  localparam int unsigned MAX_CNT = (1 << PHASE_W) * 2;

  logic             pre_done;
  logic [DIV_W-1:0] pre_div;
  logic [EXP_W-1:0] pre_exp;
  logic             pre_clamp;
  logic [PHASE_W-1:0] sp_high, sp_low;
  logic [31:0]      word;

  scl_div_prescale #(.MAX_CNT(MAX_CNT)) u_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .divisor_i (divisor_i),
    .done_o    (pre_done),
    .div_o     (pre_div),
    .exp_o     (pre_exp),
    .clamp_o   (pre_clamp)
  );

  scl_div_split #(.PHASE_W(PHASE_W)) u_split (
    .div_i   (pre_div),
    .exp_i   (pre_exp),
    .clamp_i (pre_clamp),
    .high_o  (sp_high),
    .low_o   (sp_low)
  );

  always_comb begin
    word = '0;
    word[EXP_W-1:0]           = pre_exp;
    word[LO_POS +: PHASE_W]   = sp_low;
    word[HI_POS +: PHASE_W]   = sp_high;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      clamp_o <= 1'b0;
      exp_o   <= '0;
      high_o  <= '0;
      low_o   <= '0;
      reg_o   <= '0;
    end else begin
      done_o <= pre_done;
      if (pre_done) begin
        clamp_o <= pre_clamp;
        exp_o   <= pre_exp;
        high_o  <= sp_high;
        low_o   <= sp_low;
        reg_o   <= word;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clamp_o) |-> high_o >= low_o);

  // R5
  clamp_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && clamp_o) |-> (exp_o == 4'hf && high_o == '1 && low_o == '1));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(reg_o) && $stable(clamp_o)));

  // R9
  pack_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (reg_o[3:0] == exp_o && reg_o[LO_POS +: PHASE_W] == low_o
                && reg_o[HI_POS +: PHASE_W] == high_o));
endmodule

// File: tb/scl_div_calc_test.sv
module scl_div_calc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] divisor = '0;

  logic done4, clamp4, done3, clamp3;
  logic [3:0] exp4, exp3;
  logic [3:0] hi4, lo4;
  logic [2:0] hi3, lo3;
  logic [31:0] reg4, reg3;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  scl_div_calc #(.PHASE_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .divisor_i(divisor),
    .done_o(done4), .clamp_o(clamp4), .exp_o(exp4), .high_o(hi4),
    .low_o(lo4), .reg_o(reg4));

  scl_div_calc #(.PHASE_W(3)) uut_w3 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .divisor_i(divisor),
    .done_o(done3), .clamp_o(clamp3), .exp_o(exp3), .high_o(hi3),
    .low_o(lo3), .reg_o(reg3));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (div=%0d)", req, act, exp, divisor);
    end
  endtask

  function automatic void model(input longint d, input int pw, output int e,
                                output int hi, output int lo, output bit cl);
    longint lim, q, t;
    int mask;
    mask = (1 << pw) - 1;
    lim  = (mask + 1) * 2;
    e = 0;
    if (d > lim) begin
      q = (d - 1) / lim;
      while (q > 1) begin q = q >> 1; e = e + 1; end
      e = e + 1;
    end
    cl = (e > 15);
    if (cl) begin
      e = 15; hi = mask; lo = mask;
    end else begin
      t  = (d + (64'd1 << e) - 1) >> e;
      lo = int'(t / 2);
      hi = int'(t) - lo;
      if (hi != 0) hi = hi - 1;
      if (lo != 0) lo = lo - 1;
    end
  endfunction

  logic [31:0] r4_word, r3_word;
  bit          c4_seen, c3_seen;
  logic [3:0]  e4_s, e3_s;
  logic [3:0]  h4_s, l4_s;
  logic [2:0]  h3_s, l3_s;
  int          lat4, lat3, cnt4, cnt3;

  task automatic launch(input logic [31:0] d, input bit glitch_start);
    @(negedge clk);
    divisor = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch_start) begin
      divisor = 32'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      divisor = d;
    end
    cnt4 = 0; cnt3 = 0; lat4 = 0; lat3 = 0;
    for (int k = 1; k <= 22; k++) begin
      if (done4) begin
        cnt4++; if (lat4 == 0) lat4 = k;
        c4_seen = clamp4; e4_s = exp4; h4_s = hi4; l4_s = lo4; r4_word = reg4;
      end
      if (done3) begin
        cnt3++; if (lat3 == 0) lat3 = k;
        c3_seen = clamp3; e3_s = exp3; h3_s = hi3; l3_s = lo3; r3_word = reg3;
      end
      @(negedge clk);
    end
  endtask

  task automatic verify(input logic [31:0] d);
    int e, h, l;
    bit c;
    logic [31:0] w;
    model(longint'(d), 4, e, h, l, c);
    check(cnt4 == 1, "R6 w4 single done", cnt4, 1);
    check(lat4 > 0 && lat4 <= 20, "R6 w4 latency", lat4, 20);
    check(e4_s == 4'(e), "R2 w4 exponent", e4_s, e);
    check(h4_s == 4'(h) && l4_s == 4'(l), "R3 w4 phases", {h4_s, l4_s}, {4'(h), 4'(l)});
    check(c4_seen == c, "R5 w4 clamp", c4_seen, c);
    check(c4_seen || h4_s >= l4_s, "R4 w4 order", h4_s, l4_s);
    w = {4'h0, 4'(h), 4'h0, 4'(l), 12'h0, 4'(e)};
    check(r4_word == w, "R9 w4 word", r4_word, w);
    model(longint'(d), 3, e, h, l, c);
    check(cnt3 == 1 && lat3 > 0 && lat3 <= 20, "R6 w3 done", lat3, 20);
    check(e3_s == 4'(e), "R2 w3 exponent", e3_s, e);
    check(h3_s == 3'(h) && l3_s == 3'(l), "R3 w3 phases", {h3_s, l3_s}, {3'(h), 3'(l)});
    check(c3_seen == c, "R5 w3 clamp", c3_seen, c);
    check(c3_seen || h3_s >= l3_s, "R4 w3 order", h3_s, l3_s);
    w = {5'h0, 3'(h), 5'h0, 3'(l), 12'h0, 4'(e)};
    check(r3_word == w, "R9 w3 word", r3_word, w);
  endtask

  task automatic run(input logic [31:0] d);
    launch(d, 1'b0);
    verify(d);
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(!done4 && !clamp4 && exp4 == 0 && hi4 == 0 && lo4 == 0 && reg4 == 0,
          "R1 reset w4", reg4, 0);
    check(!done3 && !clamp3 && reg3 == 0, "R1 reset w3", reg3, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int d = 0; d < 1100; d++) run(32'(d));
    for (int b = 11; b < 32; b++) begin
      run(32'd1 << b);
      run((32'd1 << b) - 1);
      run((32'd1 << b) + 1);
    end
    run(32'd524288);    // w3 largest unclamped
    run(32'd524289);
    run(32'd1048576);   // w4 largest unclamped
    run(32'd1048577);
    run(32'hffff_ffff);

    // R7: second start during the search is ignored
    launch(32'd1000000, 1'b1);
    verify(32'd1000000);

    // R8: divisor change without start leaves results held
    held = reg4;
    @(negedge clk);
    divisor = 32'd7;
    repeat (6) @(negedge clk);
    check(reg4 == held && !done4, "R8 hold w4", reg4, held);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule